// File: doc/BRIEF.md
# Geometry command front-end

This block is the host-facing entry of a drawing engine. A host writes 16-bit drawing commands one byte at a time, low byte first and high byte second. Each completed command goes into an input queue. A decoder then takes the commands from the queue in order.

Each command word has two parts. The top four bits choose what the command does, and the lower twelve bits are an operand. Some commands load that operand into one of eight 12-bit coordinate registers, four X and four Y. Other commands latch settings that are built from those registers: the destination base address, the raster width, the bit depth and the X/Y drawing limits. A line command takes a snapshot of the end points and the colour and offers it downstream on a valid/ready pair.

A busy output rises a set number of queue entries before the queue is full. A host can therefore test busy once and then send a whole burst of commands without checking again.

Top module: `geo_cmd_frontend`

## Requirements
- R1: A write with `host_hi`=0 stores `host_data` as the pending low byte; a later low write replaces it. A write with `host_hi`=1 forms the command {host_data, pending low byte} and pushes it into the queue. Only high writes push.
- R2: A command whose bits [15:12] are 0x8, 0x9, 0xA or 0xB loads bits [11:0] into X0, X1, X2 or X3. A command whose bits [15:12] are 0xC, 0xD, 0xE or 0xF loads bits [11:0] into Y0, Y1, Y2 or Y3.
- R3: The exact command 0x7F00 sets `base_addr` to {Y3, X3}, with Y3 in bits [23:12] and X3 in bits [11:0].
- R4: A command whose high byte is 0x71 sets `raster_width` to {Y3[3:0], X3}, a 16-bit value.
- R5: In a 0x71 command, bits [3:0] of the low byte are a depth code. Codes 0, 1, 3, 7 and 15 (1, 2, 4, 8 and 16 bits per pixel) are latched into `bit_depth`. Any other code leaves `bit_depth` unchanged and sets `depth_err`. Once set, `depth_err` stays high until reset.
- R6: The exact command 0x5F00 copies X0 into `limit_x` and Y0 into `limit_y`.
- R7: A command whose high byte is 0x01 raises `draw_valid`. The outputs then present X0, Y0 as the start point, X1, Y1 as the end point, and the low byte as `draw_color`. These outputs hold steady, and no further command is decoded, until `draw_ready` is seen high while `draw_valid` is high.
- R8: `busy` is a registered output. It is high exactly when the queue holds at least DEPTH-MARGIN commands.
- R9: A push into a full queue is dropped. The commands already queued are kept and decoded in order.
- R10: After reset, every coordinate register and every setting is zero, and `busy`, `draw_valid` and `depth_err` are low.
- R11: Any other command has no effect on the settings. Examples are 0x7F01, 0x5F01 and high byte 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Byte write strobe |
| host_hi | input | 1 | 1 selects the high byte, 0 selects the low byte |
| host_data | input | 8 | Byte written by the host |
| busy | output | 1 | Queue fill level has reached DEPTH-MARGIN |
| draw_valid | output | 1 | A line request is on offer |
| draw_ready | input | 1 | Downstream accepts the line request |
| draw_x0 | output | 12 | Line start X |
| draw_y0 | output | 12 | Line start Y |
| draw_x1 | output | 12 | Line end X |
| draw_y1 | output | 12 | Line end Y |
| draw_color | output | 8 | Line colour |
| base_addr | output | 24 | Destination base address |
| raster_width | output | 16 | Destination raster width in pixels |
| bit_depth | output | 4 | Latched depth code |
| limit_x | output | 12 | Maximum X |
| limit_y | output | 12 | Maximum Y |
| depth_err | output | 1 | Sticky flag for an invalid depth code |

## Verification
The bench builds the block with DEPTH=16 and MARGIN=5, so busy is expected to rise at eleven queued commands. A held line request stops the decoder. With the decoder stopped, a short run of writes fills the queue up to the busy threshold and then past full. The value of X0 in the next line request then shows that the write into the full queue was dropped, and that the last accepted entry is the one that took effect.

// File: rtl/geo_cmd_pkg.sv
package geo_cmd_pkg;

    typedef struct packed {
        logic [3:0]  op;
        logic [11:0] arg;
    } cmd_t;

    localparam logic [15:0] CMD_SET_BASE   = 16'h7F00;
    localparam logic [15:0] CMD_SET_LIMITS = 16'h5F00;
    localparam logic [7:0]  HI_SET_RASTER  = 8'h71;
    localparam logic [7:0]  HI_DRAW_LINE   = 8'h01;

    function automatic logic depth_code_ok(input logic [3:0] code);
        return (code == 4'd0) || (code == 4'd1) || (code == 4'd3) ||
               (code == 4'd7) || (code == 4'd15);
    endfunction

endpackage

// File: rtl/geo_byte_pair.sv
module geo_byte_pair
    import geo_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr,
    input  logic       host_hi,
    input  logic [7:0] host_data,
    output logic       push,
    output cmd_t       push_cmd
);
    logic [7:0] low_q;

    always_ff @(posedge clk) begin
        if (rst)
            low_q <= '0;
        else if (host_wr && !host_hi)
            low_q <= host_data;
    end

    assign push     = host_wr && host_hi;
    assign push_cmd = cmd_t'({host_data, low_q});

endmodule

// File: rtl/geo_cmd_fifo.sv
module geo_cmd_fifo
    import geo_cmd_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int MARGIN = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr,
    input  cmd_t                       wr_cmd,
    input  logic                       rd,
    output cmd_t                       rd_cmd,
    output logic                       empty,
    output logic                       busy,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int AW  = $clog2(DEPTH);
    localparam int LW  = $clog2(DEPTH+1);
    localparam int THR = DEPTH - MARGIN;

    cmd_t          mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [LW-1:0] lvl_next;
    logic          do_wr, do_rd;

    assign empty  = (level == '0);
    assign do_wr  = wr && (level != LW'(DEPTH));
    assign do_rd  = rd && !empty;
    assign rd_cmd = mem[rp];

    always_comb lvl_next = level + LW'(do_wr) - LW'(do_rd);

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_cmd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
            busy  <= 1'b0;
        end else begin
            if (do_wr) wp <= wp + AW'(1);
            if (do_rd) rp <= rp + AW'(1);
            level <= lvl_next;
            busy  <= (lvl_next >= LW'(THR));
        end
    end

endmodule

// File: rtl/geo_cmd_decoder.sv
module geo_cmd_decoder
    import geo_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_avail,
    input  cmd_t        cmd,
    output logic        cmd_pop,
    output logic        draw_valid,
    input  logic        draw_ready,
    output logic [11:0] draw_x0,
    output logic [11:0] draw_y0,
    output logic [11:0] draw_x1,
    output logic [11:0] draw_y1,
    output logic [7:0]  draw_color,
    output logic [23:0] base_addr,
    output logic [15:0] raster_width,
    output logic [3:0]  bit_depth,
    output logic [11:0] limit_x,
    output logic [11:0] limit_y,
    output logic        depth_err
);
    logic [11:0] xr [4];
    logic [11:0] yr [4];
    logic [15:0] word;
    logic [7:0]  hi_b, lo_b;

    assign word    = cmd;
    assign hi_b    = word[15:8];
    assign lo_b    = word[7:0];
    assign cmd_pop = cmd_avail && (!draw_valid || draw_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) begin
                xr[i] <= '0;
                yr[i] <= '0;
            end
            draw_valid   <= 1'b0;
            draw_x0      <= '0;
            draw_y0      <= '0;
            draw_x1      <= '0;
            draw_y1      <= '0;
            draw_color   <= '0;
            base_addr    <= '0;
            raster_width <= '0;
            bit_depth    <= '0;
            limit_x      <= '0;
            limit_y      <= '0;
            depth_err    <= 1'b0;
        end else begin
            if (draw_valid && draw_ready) draw_valid <= 1'b0;
            if (cmd_pop) begin
                for (int i = 0; i < 4; i++) begin
                    if (cmd.op == 4'(8 + i))  xr[i] <= cmd.arg;
                    if (cmd.op == 4'(12 + i)) yr[i] <= cmd.arg;
                end
                if (word == CMD_SET_BASE)
                    base_addr <= {yr[3], xr[3]};
                if (word == CMD_SET_LIMITS) begin
                    limit_x <= xr[0];
                    limit_y <= yr[0];
                end
                if (hi_b == HI_SET_RASTER) begin
                    raster_width <= {yr[3][3:0], xr[3]};
                    if (depth_code_ok(lo_b[3:0]))
                        bit_depth <= lo_b[3:0];
                    else
                        depth_err <= 1'b1;
                end
                if (hi_b == HI_DRAW_LINE) begin
                    draw_valid <= 1'b1;
                    draw_x0    <= xr[0];
                    draw_y0    <= yr[0];
                    draw_x1    <= xr[1];
                    draw_y1    <= yr[1];
                    draw_color <= lo_b;
                end
            end
        end
    end

endmodule

// File: rtl/geo_cmd_frontend.sv
module geo_cmd_frontend
    import geo_cmd_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int MARGIN = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic        host_hi,
    input  logic [7:0]  host_data,
    output logic        busy,
    output logic        draw_valid,
    input  logic        draw_ready,
    output logic [11:0] draw_x0,
    output logic [11:0] draw_y0,
    output logic [11:0] draw_x1,
    output logic [11:0] draw_y1,
    output logic [7:0]  draw_color,
    output logic [23:0] base_addr,
    output logic [15:0] raster_width,
    output logic [3:0]  bit_depth,
    output logic [11:0] limit_x,
    output logic [11:0] limit_y,
    output logic        depth_err
);
    localparam int LW = $clog2(DEPTH+1);

    logic          push, fifo_empty, fifo_pop;
    cmd_t          push_cmd, head_cmd;
    logic [LW-1:0] fifo_level;

    geo_byte_pair i_pair (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_hi(host_hi),
        .host_data(host_data), .push(push), .push_cmd(push_cmd)
    );

    geo_cmd_fifo #(.DEPTH(DEPTH), .MARGIN(MARGIN)) i_fifo (
        .clk(clk), .rst(rst), .wr(push), .wr_cmd(push_cmd),
        .rd(fifo_pop), .rd_cmd(head_cmd), .empty(fifo_empty),
        .busy(busy), .level(fifo_level)
    );

    geo_cmd_decoder i_dec (
        .clk(clk), .rst(rst), .cmd_avail(!fifo_empty), .cmd(head_cmd),
        .cmd_pop(fifo_pop), .draw_valid(draw_valid), .draw_ready(draw_ready),
        .draw_x0(draw_x0), .draw_y0(draw_y0), .draw_x1(draw_x1),
        .draw_y1(draw_y1), .draw_color(draw_color), .base_addr(base_addr),
        .raster_width(raster_width), .bit_depth(bit_depth),
        .limit_x(limit_x), .limit_y(limit_y), .depth_err(depth_err)
    );

endmodule

// File: rtl/geo_cmd_frontend_checker.sv
module geo_cmd_frontend_checker #(
    parameter int DEPTH  = 64,
    parameter int MARGIN = 32
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       busy,
    input logic                       draw_valid,
    input logic                       draw_ready,
    input logic [11:0]                draw_x0,
    input logic [7:0]                 draw_color,
    input logic [23:0]                base_addr,
    input logic [3:0]                 bit_depth,
    input logic                       depth_err,
    input logic                       fifo_pop,
    input logic [$clog2(DEPTH+1)-1:0] fifo_level
);
    localparam int LW = $clog2(DEPTH+1);

    assert_draw_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (draw_valid && !draw_ready) |=> (draw_valid && $stable(draw_x0) && $stable(draw_color)));

    assert_busy_level_R8: assert property (@(posedge clk) disable iff (rst)
        busy == (fifo_level >= LW'(DEPTH - MARGIN)));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= LW'(DEPTH));

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        depth_err |=> depth_err);

    assert_depth_legal_R5: assert property (@(posedge clk) disable iff (rst)
        (bit_depth == 4'd0 || bit_depth == 4'd1 || bit_depth == 4'd3 ||
         bit_depth == 4'd7 || bit_depth == 4'd15));

    assert_base_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !fifo_pop |=> $stable(base_addr));

endmodule

bind geo_cmd_frontend geo_cmd_frontend_checker #(.DEPTH(DEPTH), .MARGIN(MARGIN)) i_chk (
    .clk(clk), .rst(rst), .busy(busy), .draw_valid(draw_valid),
    .draw_ready(draw_ready), .draw_x0(draw_x0), .draw_color(draw_color),
    .base_addr(base_addr), .bit_depth(bit_depth), .depth_err(depth_err),
    .fifo_pop(fifo_pop), .fifo_level(fifo_level)
);

// File: tb/test_geo_cmd_frontend.sv
`timescale 1ns/1ps
module test_geo_cmd_frontend;
    localparam int DEPTH  = 16;
    localparam int MARGIN = 5;

    logic clk = 0, rst = 1;
    logic host_wr = 0, host_hi = 0, draw_ready = 0;
    logic [7:0] host_data = 0;
    logic busy, draw_valid, depth_err;
    logic [11:0] draw_x0, draw_y0, draw_x1, draw_y1, limit_x, limit_y;
    logic [7:0] draw_color;
    logic [23:0] base_addr;
    logic [15:0] raster_width;
    logic [3:0] bit_depth;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    geo_cmd_frontend #(.DEPTH(DEPTH), .MARGIN(MARGIN)) i_geo_cmd_frontend (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_hi(host_hi),
        .host_data(host_data), .busy(busy), .draw_valid(draw_valid),
        .draw_ready(draw_ready), .draw_x0(draw_x0), .draw_y0(draw_y0),
        .draw_x1(draw_x1), .draw_y1(draw_y1), .draw_color(draw_color),
        .base_addr(base_addr), .raster_width(raster_width),
        .bit_depth(bit_depth), .limit_x(limit_x), .limit_y(limit_y),
        .depth_err(depth_err)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic wr_byte(input bit hi, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1; host_hi = hi; host_data = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic send(input logic [15:0] c);
        wr_byte(0, c[7:0]);
        wr_byte(1, c[15:8]);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic accept_draw;
        @(negedge clk); draw_ready = 1;
        @(negedge clk); draw_ready = 0;
    endtask

    task automatic t_reset;
        chk_eq("R10 busy", busy, 0);
        chk_eq("R10 draw_valid", draw_valid, 0);
        chk_eq("R10 depth_err", depth_err, 0);
        chk_eq("R10 base", base_addr, 0);
        chk_eq("R10 width", raster_width, 0);
        chk_eq("R10 limits", {limit_x, limit_y}, 0);
    endtask

    task automatic t_draw;
        send(16'h8012); send(16'hC034); send(16'h9ABC); send(16'hDFED);
        send(16'h01A5);
        chk_eq("R7 valid", draw_valid, 1);
        chk_eq("R2 R7 x0", draw_x0, 12'h012);
        chk_eq("R2 R7 y0", draw_y0, 12'h034);
        chk_eq("R2 R7 x1", draw_x1, 12'hABC);
        chk_eq("R2 R7 y1", draw_y1, 12'hFED);
        chk_eq("R7 color", draw_color, 8'hA5);
        send(16'h8777);
        chk_eq("R7 held x0", draw_x0, 12'h012);
        accept_draw();
        chk_eq("R7 released", draw_valid, 0);
        send(16'h0111);
        chk_eq("R7 x0 after stall", draw_x0, 12'h777);
        accept_draw();
    endtask

    task automatic t_pairing;
        wr_byte(0, 8'hAA);
        wr_byte(0, 8'h34);
        wr_byte(1, 8'h81);
        @(negedge clk); @(negedge clk);
        send(16'h0107);
        chk_eq("R1 lone low replaced", draw_x0, 12'h134);
        accept_draw();
    endtask

    task automatic t_settings;
        send(16'hF001); send(16'hB200); send(16'h7F00);
        chk_eq("R3 base", base_addr, 24'h001200);
        send(16'hB777); send(16'h7F01); send(16'h5F01); send(16'h0200);
        chk_eq("R11 base unchanged", base_addr, 24'h001200);
        chk_eq("R11 no draw", draw_valid, 0);
        chk_eq("R11 limits unchanged", {limit_x, limit_y}, 0);
        send(16'hF000); send(16'hB140); send(16'h7103);
        chk_eq("R4 width", raster_width, 16'h0140);
        chk_eq("R5 depth", bit_depth, 4'd3);
        send(16'hF00F); send(16'hBFFF); send(16'h710F);
        chk_eq("R4 width max", raster_width, 16'hFFFF);
        chk_eq("R5 depth 15", bit_depth, 4'd15);
        chk_eq("R5 no err yet", depth_err, 0);
        send(16'h7102);
        chk_eq("R5 invalid kept", bit_depth, 4'd15);
        chk_eq("R5 err set", depth_err, 1);
        send(16'h7107);
        chk_eq("R5 err sticky", depth_err, 1);
        chk_eq("R5 depth 7", bit_depth, 4'd7);
        send(16'h8140); send(16'hC0C8); send(16'h5F00);
        chk_eq("R6 limit x", limit_x, 12'h140);
        chk_eq("R6 limit y", limit_y, 12'h0C8);
    endtask

    task automatic t_fill;
        send(16'h0199);
        chk_eq("R7 stall draw", draw_valid, 1);
        for (int i = 1; i <= DEPTH; i++) begin
            wr_byte(0, 8'(i));
            wr_byte(1, 8'h80);
            @(negedge clk);
            if (i == DEPTH - MARGIN - 1) chk_eq("R8 busy below", busy, 0);
            if (i == DEPTH - MARGIN)     chk_eq("R8 busy at level", busy, 1);
        end
        wr_byte(0, 8'hFF);
        wr_byte(1, 8'h8F);
        @(negedge clk);
        chk_eq("R8 busy full", busy, 1);
        accept_draw();
        repeat (DEPTH + 4) @(negedge clk);
        chk_eq("R8 busy drained", busy, 0);
        send(16'h0122);
        chk_eq("R9 dropped push", draw_x0, 12'(DEPTH));
        chk_eq("R9 color", draw_color, 8'h22);
        accept_draw();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_draw();
        t_pairing();
        t_settings();
        t_fill();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule